// File: doc/BRIEF.md
# Main-Oscillator Stop and Restart Guard

This block watches a main oscillator from the always-running internal-oscillator domain and reports when it stops or comes back. The main-clock side supplies only a toggling signal; the guard passes it through a two-flop synchroniser, measures the gaps between its edges, and derives a "main clock not oscillating" monitor bit together with single-cycle stop and restart events. Events are produced only while detection is enabled.

Software controls the guard through one 8-bit control and status register on a plain register bus: write strobe plus write data, with a combinational read port. Writes land only while the external write-protect enable is 1, and the external clock-change lock freezes the detection-enable bit. Register bit positions: bit0 detection enable, bit1 clock select (0 = main or PLL, 1 = internal oscillator), bit2 sticky detection flag, bit3 monitor (read-only, 1 = main clock not oscillating), bits 6:4 always read 0, bit7 action select (0 = detection reset, 1 = interrupt).

On a detected stop the guard either asks for a detection reset, or raises an interrupt and, when the CPU runs directly from the main clock, fails the clock select over to the internal oscillator. When the CPU runs from the PLL the select is left alone and software must switch it. The interrupt pulse fires only on the flag's 0-to-1 transition. The clock multiplexer, PLL, stop mode and interrupt controller live outside; only their control signals appear here.

Top module: `osc_guard`

## Requirements
- R1: After reset the register reads 0x02, and the interrupt and detection-reset outputs are 0.
- R2: A write while the write-protect enable is 0 changes no register bit.
- R3: While the clock-change lock is 1, a write leaves bit0 (detection enable) unchanged; the other writable bits still take the written values.
- R4: With the defaults, STOP_CYC (8) internal-oscillator cycles without a synchronised toggle edge set bit3 to 1. RESTART_EDGES (4) further edges, with no gap of STOP_CYC cycles between them, clear bit3. While bit0 is 1, each of these transitions sets bit2.
- R5: While bit0 is 0, a stop or a restart changes bit3 only. Bit2 stays 0, and neither the interrupt nor the detection-reset request is asserted.
- R6: With bit0 = 1, bit7 = 1 and the CPU source input at 0 (main clock), a detected stop sets bit1 to 1, sets bit2, and pulses the interrupt once.
- R7: With bit0 = 1, bit7 = 1 and the CPU source input at 1 (PLL), a detected stop leaves bit1 unchanged, sets bit2, and pulses the interrupt once.
- R8: Bit2 is cleared only by a write with data bit2 = 0. Writing 1 to bit2 leaves it unchanged.
- R9: The interrupt pulses only when bit2 goes from 0 to 1. A stop or restart that occurs while bit2 is already 1 raises no interrupt.
- R10: With bit0 = 1 and bit7 = 0, a detected stop pulses the detection-reset request for one cycle and raises no interrupt. Bits 0, 1 and 7 keep their values and bit2 reads 0. A later restart sets bit2 and raises no interrupt.
- R11: While bit0 = 1 and bit3 = 1, a write of 0 to bit1 is ignored.
- R12: Bits 6:4 read 0 whatever value is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal-oscillator clock, always running |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value (combinational) |
| wp_en | input | 1 | Write-protect enable; writes land only when 1 |
| clk_lock | input | 1 | Clock-change lock; freezes bit0 when 1 |
| cpu_on_pll | input | 1 | CPU clock source: 0 = main clock, 1 = PLL |
| main_toggle | input | 1 | Toggling signal from the main-clock domain |
| sel_internal | output | 1 | Clock-source select to the external multiplexer (bit1) |
| irq_pulse | output | 1 | One-cycle interrupt request |
| det_reset_req | output | 1 | One-cycle detection-reset request |

## Verification
A wrong gap or edge count inside the activity tracker shows up on bit3 at the read port, STOP_CYC plus the three synchroniser and edge-detect cycles after the last main-clock edge. The register then shows it one cycle later, on bit2 and sel_internal. A flag that was already 1 when it should have been 0 shows up as a missing interrupt at the next event. A wrong protection or lock decision shows up in the read value on the cycle after the write. A detection reset that wrongly clears or keeps fields shows up in the read value on the cycle after det_reset_req.

// File: rtl/osc_guard_pkg.sv
package osc_guard_pkg;
  localparam int REG_W = 8;

  localparam int B_EN   = 0;
  localparam int B_SEL  = 1;
  localparam int B_FLAG = 2;
  localparam int B_MON  = 3;
  localparam int B_ACT  = 7;

  typedef struct packed {
    logic act;
    logic flag;
    logic sel;
    logic en;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{act: 1'b0, flag: 1'b0, sel: 1'b1, en: 1'b0};
endpackage

// File: rtl/osc_edge_sync.sv
module osc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic edge_seen
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain  <= '0;
      last_q <= 1'b0;
    end else begin
      chain  <= {chain[STAGES-2:0], async_in};
      last_q <= chain[STAGES-1];
    end
  end

  assign edge_seen = chain[STAGES-1] ^ last_q;
endmodule

// File: rtl/osc_activity.sv
module osc_activity #(
  parameter int STOP_CYC      = 8,
  parameter int RESTART_EDGES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_seen,
  input  logic enable,
  output logic dead,
  output logic stop_evt,
  output logic restart_evt
);
  localparam int SW = $clog2(STOP_CYC + 1);
  localparam int EW = $clog2(RESTART_EDGES + 1);
  localparam logic [SW-1:0] GAP_LAST  = SW'(STOP_CYC - 1);
  localparam logic [SW-1:0] GAP_FULL  = SW'(STOP_CYC);
  localparam logic [EW-1:0] EDGE_LAST = EW'(RESTART_EDGES - 1);

  logic [SW-1:0] gap_cnt;
  logic [EW-1:0] run_cnt;
  logic          gap_hit;
  logic          back_hit;

  assign gap_hit  = !edge_seen && (gap_cnt == GAP_LAST);
  assign back_hit = dead && edge_seen && (run_cnt == EDGE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt     <= '0;
      run_cnt     <= '0;
      dead        <= 1'b0;
      stop_evt    <= 1'b0;
      restart_evt <= 1'b0;
    end else begin
      if (edge_seen)              gap_cnt <= '0;
      else if (gap_cnt != GAP_FULL) gap_cnt <= gap_cnt + 1'b1;

      if (!dead) begin
        run_cnt <= '0;
        if (gap_hit) dead <= 1'b1;
      end else if (gap_hit) begin
        run_cnt <= '0;
      end else if (back_hit) begin
        dead    <= 1'b0;
        run_cnt <= '0;
      end else if (edge_seen) begin
        run_cnt <= run_cnt + 1'b1;
      end

      stop_evt    <= gap_hit && !dead && enable;
      restart_evt <= back_hit && enable;
    end
  end

  assert_stop_marks_dead_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |-> dead);
  assert_restart_marks_alive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart_evt |-> !dead);
  assert_events_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(stop_evt && restart_evt));
endmodule

// File: rtl/osc_ctrl_reg.sv
module osc_ctrl_reg
  import osc_guard_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             wp_en,
  input  logic             clk_lock,
  input  logic             cpu_on_pll,
  input  logic             dead,
  input  logic             stop_evt,
  input  logic             restart_evt,
  output logic [REG_W-1:0] rd_data,
  output logic             enable,
  output logic             sel_internal,
  output logic             irq_pulse,
  output logic             det_reset_req
);
  ctrl_t cur, nxt;
  logic  wr_ok, det_any, irq_n, rr_n;

  assign wr_ok   = wr_en && wp_en;
  assign det_any = stop_evt || restart_evt;

  always_comb begin
    nxt = cur;
    if (wr_ok) begin
      if (!clk_lock) nxt.en = wr_data[B_EN];
      if (!(!wr_data[B_SEL] && cur.en && dead)) nxt.sel = wr_data[B_SEL];
      if (!wr_data[B_FLAG]) nxt.flag = 1'b0;
      nxt.act = wr_data[B_ACT];
    end
    if (stop_evt && !cur.act)  nxt.flag = 1'b0;
    else if (det_any)          nxt.flag = 1'b1;
    if (stop_evt && cur.act && !cpu_on_pll) nxt.sel = 1'b1;
    irq_n = det_any && cur.act && !cur.flag;
    rr_n  = stop_evt && !cur.act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur           <= CTRL_RESET;
      irq_pulse     <= 1'b0;
      det_reset_req <= 1'b0;
    end else begin
      cur           <= nxt;
      irq_pulse     <= irq_n;
      det_reset_req <= rr_n;
    end
  end

  always_comb begin
    rd_data         = '0;
    rd_data[B_EN]   = cur.en;
    rd_data[B_SEL]  = cur.sel;
    rd_data[B_FLAG] = cur.flag;
    rd_data[B_MON]  = dead;
    rd_data[B_ACT]  = cur.act;
  end

  assign enable       = cur.en;
  assign sel_internal = cur.sel;

  assert_enable_held_by_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur.en) |-> $past(wr_en && wp_en && !clk_lock));
  assert_flag_clears_by_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cur.flag) |-> ($past(wr_en && wp_en && !wr_data[B_FLAG]) || $past(stop_evt && !cur.act)));
  assert_irq_on_flag_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> (cur.flag && !$past(cur.flag)));
  assert_sel_falls_by_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cur.sel) |-> $past(wr_en && wp_en && !wr_data[B_SEL] && !(cur.en && dead)));
  assert_reset_req_no_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    det_reset_req |-> (!irq_pulse && !cur.flag));
  assert_no_write_when_protected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && !wp_en && !stop_evt && !restart_evt) |-> $stable(cur.act));
endmodule

// File: rtl/osc_guard.sv
module osc_guard
  import osc_guard_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int STOP_CYC      = 8,
  parameter int RESTART_EDGES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             wp_en,
  input  logic             clk_lock,
  input  logic             cpu_on_pll,
  input  logic             main_toggle,
  output logic             sel_internal,
  output logic             irq_pulse,
  output logic             det_reset_req
);
  logic edge_seen, dead, stop_evt, restart_evt, enable;

  osc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(main_toggle), .edge_seen(edge_seen)
  );

  osc_activity #(.STOP_CYC(STOP_CYC), .RESTART_EDGES(RESTART_EDGES)) u_act (
    .clk(clk), .rst_n(rst_n), .edge_seen(edge_seen), .enable(enable),
    .dead(dead), .stop_evt(stop_evt), .restart_evt(restart_evt)
  );

  osc_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wp_en(wp_en), .clk_lock(clk_lock), .cpu_on_pll(cpu_on_pll),
    .dead(dead), .stop_evt(stop_evt), .restart_evt(restart_evt),
    .rd_data(rd_data), .enable(enable), .sel_internal(sel_internal),
    .irq_pulse(irq_pulse), .det_reset_req(det_reset_req)
  );

  assert_events_need_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse || det_reset_req) |-> $past(enable));
endmodule

// File: tb/osc_guard_bench.sv
module osc_guard_bench;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       wp_en = 1'b1;
  logic       clk_lock = 1'b0;
  logic       cpu_on_pll = 1'b0;
  logic       main_toggle = 1'b0;
  logic       main_run = 1'b1;
  logic       sel_internal, irq_pulse, det_reset_req;

  int total = 0;
  int bad = 0;
  int irq_cnt = 0;
  int rr_cnt = 0;

  always #(CLK_NS/2) clk = ~clk;

  initial forever begin
    #(CLK_NS*2 + 3);
    if (main_run) main_toggle = ~main_toggle;
  end

  always @(negedge clk) begin
    if (irq_pulse) irq_cnt++;
    if (det_reset_req) rr_cnt++;
  end

  osc_guard u_osc_guard (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .wp_en(wp_en), .clk_lock(clk_lock), .cpu_on_pll(cpu_on_pll),
    .main_toggle(main_toggle), .sel_internal(sel_internal),
    .irq_pulse(irq_pulse), .det_reset_req(det_reset_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic stop_main();
    main_run = 1'b0; idle(30);
  endtask

  task automatic start_main();
    main_run = 1'b1; idle(40);
  endtask

  task automatic t_reset();
    chk("R1 reg", rd_data, 8'h02);
    chk("R1 irq", irq_cnt, 0);
    chk("R1 rstreq", rr_cnt, 0);
    chk("R1 sel pin", sel_internal, 1);
  endtask

  task automatic t_protect();
    wp_en = 1'b0; wr(8'hFF); idle(1);
    chk("R2 protected write", rd_data, 8'h02);
    wp_en = 1'b1; wr(8'h70); idle(1);
    chk("R12 reserved bits", rd_data, 8'h00);
  endtask

  task automatic t_lock();
    clk_lock = 1'b1; wr(8'h83); idle(1);
    chk("R3 enable frozen", rd_data, 8'h82);
    clk_lock = 1'b0; wr(8'h01); idle(1);
    chk("R3 enable writes when unlocked", rd_data, 8'h01);
    wr(8'h00);
  endtask

  task automatic t_disabled();
    int i0, r0;
    i0 = irq_cnt; r0 = rr_cnt;
    stop_main();
    chk("R5 disabled stop monitor only", rd_data, 8'h08);
    start_main();
    chk("R5 disabled restart", rd_data, 8'h00);
    chk("R5 no irq", irq_cnt, i0);
    chk("R5 no reset req", rr_cnt, r0);
  endtask

  task automatic t_failover();
    int i0;
    cpu_on_pll = 1'b0; wr(8'h81); i0 = irq_cnt;
    stop_main();
    chk("R6 failover reg", rd_data, 8'h8F);
    chk("R6 sel pin", sel_internal, 1);
    chk("R4 R6 one irq", irq_cnt, i0 + 1);
    wr(8'h85); idle(1);
    chk("R11 sel clear ignored while dead", rd_data, 8'h8F);
    start_main();
    chk("R4 R9 restart with flag set", rd_data, 8'h87);
    chk("R9 no second irq", irq_cnt, i0 + 1);
    wr(8'h87); idle(1);
    chk("R8 write 1 keeps flag", rd_data, 8'h87);
    wr(8'h83); idle(1);
    chk("R8 write 0 clears flag", rd_data, 8'h83);
    wr(8'h81); idle(1);
    chk("R11 sel clear allowed while alive", rd_data, 8'h81);
  endtask

  task automatic t_pll();
    int i0;
    cpu_on_pll = 1'b1; i0 = irq_cnt;
    stop_main();
    chk("R7 pll keeps sel", rd_data, 8'h8D);
    chk("R7 irq", irq_cnt, i0 + 1);
    wr(8'h81); idle(1);
    chk("R8 clear while dead", rd_data, 8'h89);
    start_main();
    chk("R9 restart irq on rise", irq_cnt, i0 + 2);
    chk("R4 restart reg", rd_data, 8'h85);
    wr(8'h01); cpu_on_pll = 1'b0;
  endtask

  task automatic t_reset_req();
    int i0, r0;
    wr(8'h03); idle(1); i0 = irq_cnt; r0 = rr_cnt;
    stop_main();
    chk("R10 reset req once", rr_cnt, r0 + 1);
    chk("R10 no irq", irq_cnt, i0);
    chk("R10 fields kept", rd_data, 8'h0B);
    start_main();
    chk("R10 restart flag", rd_data, 8'h07);
    chk("R10 restart no irq", irq_cnt, i0);
  endtask

  initial begin
    #(CLK_NS * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_protect();
    t_lock();
    t_disabled();
    t_failover();
    t_pll();
    t_reset_req();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule